// File: doc/BRIEF.md
# Boot Load Sequencer

This block brings a machine up from a chosen device with no processor help. When a load is requested, hardware makes up the first command itself: a read with opcode 0x02, aimed at the selected device, with command chaining assumed. The record the device returns is stored as a 24-byte area starting at address 0. The sequencer then treats the bytes just stored as the rest of the load program. It fetches command words from address 8 and onward, takes branches, and issues each command to the device. When a command that does not chain ends cleanly, it reads the double word at address 0 and hands it out as the initial processor state word.

A command word is a big-endian double word: the byte at the lowest address sits in bits 63:56. Byte 0 is the opcode. Bytes 1-3 hold a data or branch address. Bit 6 of byte 4 (word bit 30) is the chain flag. Bytes 6-7 hold the byte count. Any positioning the device needs before it answers opcode 0x02, such as a disk moving to cylinder 0 head 0 and skipping its track descriptor record, happens inside the device. The sequencer only sees the record stream and a final status.

Three handshakes are valid/ready: the device command, the device byte stream and the memory write. A sender must hold its valid and its payload steady until ready is seen. The byte stream is only ready when memory can take the write, or when the command's count is used up; after that point, excess bytes are consumed and dropped. The device reports end status on `dend_valid` only after its last byte has been accepted. Memory reads are plain: data comes back one cycle after `mem_ren`.

Top module: `boot_loader`

## Requirements
- R1: A `load_req` seen while idle makes the next cycle present a device command with opcode 0x02 and the device number sampled with the request. The record is stored starting at address 0.
- R2: Each record byte is written to the next address from the command's data address, up to the command's count. Bytes beyond the count are accepted and dropped, with no memory write.
- R3: After a command that has the chain flag (word bit 30) ends with good status, the next command word is fetched from 8 bytes past the current one. For the implied read this is address 8, then 16, and so on. Each fetched word's opcode and device number are issued as the next command.
- R4: A word whose opcode low nibble is 0x8 is a branch. It issues no device command, and fetching continues at its address field. A branch to an address that is not a multiple of 8, or a branch that directly follows another branch, aborts the load.
- R5: When a command without the chain flag ends with good status, the double word at address 0 is read. `done_o` then pulses high for exactly one cycle, three cycles after that status, with `psw_o` valid in the same cycle.
- R6: A device status with `dend_err` set aborts the load. `wait_o` goes high in the next cycle and stays high, `err_dev_o` holds the device number, and no further command is issued.
- R7: If the implied first read ends with fewer than 24 bytes, there is no valid load text, so the load aborts into the wait state.
- R8: A fetched command word whose opcode low nibble is 0x0 aborts the load into the wait state.
- R9: `load_req` is ignored while a load is in progress. From the wait state it starts a new load and clears `wait_o` in the next cycle.
- R10: A device command that is not taken holds its valid, opcode and device number. Memory write addresses step by one per accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_req | input | 1 | Start a load (sampled while idle) |
| dev_num | input | DEV_W | Device to load from |
| dcmd_valid | output | 1 | Device command offered |
| dcmd_ready | input | 1 | Device takes the command |
| dcmd_op | output | 8 | Command opcode |
| dcmd_dev | output | DEV_W | Addressed device |
| drec_valid | input | 1 | Record byte offered |
| drec_ready | output | 1 | Record byte taken |
| drec_data | input | 8 | Record byte |
| dend_valid | input | 1 | Device end status strobe |
| dend_err | input | 1 | End status reports error or unit check |
| mem_wvalid | output | 1 | Memory byte write offered |
| mem_wready | input | 1 | Memory takes the write |
| mem_waddr | output | AW | Write byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ren | output | 1 | Double-word read strobe |
| mem_raddr | output | AW | Read address (multiple of 8) |
| mem_rdata | input | 64 | Read data, one cycle after the strobe |
| done_o | output | 1 | One-cycle load-complete pulse |
| psw_o | output | 64 | Initial processor state word |
| wait_o | output | 1 | Load aborted, machine waits |
| err_dev_o | output | DEV_W | Device number of the aborted load |

## Verification
Each outcome has a fixed delay:
- The implied command is visible in the cycle right after the accepting edge.
- An abort shows on `wait_o` one cycle after the failing end status.
- Completion shows on `done_o` three cycles after the final good status: one cycle to issue the read, one for the memory latency, and one for the output register.

The bench's device model notes the cycle in which it raises each end status. The bench samples outputs on falling edges and compares the exact cycle distance, rather than just waiting for the signals. It also looks at the cycle after `done_o` to confirm the pulse lasts a single cycle.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_XFER,
    ST_FETCH,
    ST_DEC,
    ST_PSW,
    ST_PDONE
  } boot_st_e;

  localparam logic [7:0] OP_LOAD_READ = 8'h02;
  localparam logic [3:0] NIB_BRANCH   = 4'h8;
  localparam logic [3:0] NIB_INVALID  = 4'h0;
  localparam int         CHAIN_BIT    = 30;

  typedef struct packed {
    logic [7:0]  op;
    logic [23:0] addr;
    logic        chain;
    logic [15:0] count;
    logic        is_branch;
    logic        is_invalid;
  } cmd_word_t;

endpackage

// File: rtl/boot_word_decode.sv
module boot_word_decode
  import boot_pkg::*;
(
  input  logic [63:0] word_i,
  output cmd_word_t   cw_o
);
  logic unused_bits;
  assign unused_bits = ^{word_i[31], word_i[29:16]};

  always_comb begin
    cw_o.op         = word_i[63:56];
    cw_o.addr       = word_i[55:32];
    cw_o.chain      = word_i[CHAIN_BIT];
    cw_o.count      = word_i[15:0];
    cw_o.is_branch  = (word_i[59:56] == NIB_BRANCH);
    cw_o.is_invalid = (word_i[59:56] == NIB_INVALID);
  end
endmodule

// File: rtl/boot_byte_mover.sv
module boot_byte_mover #(
  parameter int AW    = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [AW-1:0]    base_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             active_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  input  logic             wr_ready_i,
  output logic             wr_valid_o,
  output logic [AW-1:0]    wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic [CNT_W-1:0] taken_o
);
  logic [AW-1:0]    ptr_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] taken_q;
  logic             room;
  logic             beat;

  assign room       = (rem_q != '0);
  assign wr_valid_o = active_i && in_valid_i && room;
  assign in_ready_o = active_i && (!room || wr_ready_i);
  assign wr_addr_o  = ptr_q;
  assign wr_data_o  = in_data_i;
  assign taken_o    = taken_q;
  assign beat       = wr_valid_o && wr_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      rem_q   <= '0;
      taken_q <= '0;
    end else if (start_i) begin
      ptr_q   <= base_i;
      rem_q   <= count_i;
      taken_q <= '0;
    end else if (beat) begin
      ptr_q   <= ptr_q + AW'(1);
      rem_q   <= rem_q - CNT_W'(1);
      taken_q <= taken_q + CNT_W'(1);
    end
  end

  // R10: consecutive stored bytes land on consecutive addresses
  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && rem_q != CNT_W'(1)) |=> (wr_addr_o == $past(wr_addr_o) + AW'(1)));

  // R2: bytes past the count are consumed without moving the write pointer
  a_r2_drop_excess: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid_i && in_ready_o && !room) |=> $stable(wr_addr_o));
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DEV_W      = 8,
  parameter int CNT_W      = 16,
  parameter int LOAD_BYTES = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_req,
  input  logic [DEV_W-1:0] dev_num,
  output logic             dcmd_valid,
  input  logic             dcmd_ready,
  output logic [7:0]       dcmd_op,
  output logic [DEV_W-1:0] dcmd_dev,
  input  logic             drec_valid,
  output logic             drec_ready,
  input  logic [7:0]       drec_data,
  input  logic             dend_valid,
  input  logic             dend_err,
  output logic             mem_wvalid,
  input  logic             mem_wready,
  output logic [AW-1:0]    mem_waddr,
  output logic [7:0]       mem_wdata,
  output logic             mem_ren,
  output logic [AW-1:0]    mem_raddr,
  input  logic [63:0]      mem_rdata,
  output logic             done_o,
  output logic [63:0]      psw_o,
  output logic             wait_o,
  output logic [DEV_W-1:0] err_dev_o
);
  localparam int            WORD_BYTES = 8;
  localparam logic [AW-1:0] STEP       = AW'(WORD_BYTES);
  localparam logic [CNT_W-1:0] FIRST_LEN = CNT_W'(LOAD_BYTES);

  boot_st_e         st_q;
  logic [DEV_W-1:0] dev_q, errdev_q;
  logic [7:0]       op_q;
  logic [AW-1:0]    daddr_q, pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             chain_q, first_q, prev_br_q;
  logic [63:0]      psw_q;
  logic             done_q, wait_q;

  cmd_word_t        cw;
  logic [CNT_W-1:0] taken;
  logic             start_xfer, mover_active, short_first, misaligned;
  logic [AW-1:0]    br_target;

  boot_word_decode u_dec (
    .word_i (mem_rdata),
    .cw_o   (cw)
  );

  assign start_xfer   = (st_q == ST_CMD) && dcmd_ready;
  assign mover_active = (st_q == ST_XFER);

  boot_byte_mover #(.AW(AW), .CNT_W(CNT_W)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_xfer),
    .base_i     (daddr_q),
    .count_i    (cnt_q),
    .active_i   (mover_active),
    .in_valid_i (drec_valid),
    .in_data_i  (drec_data),
    .in_ready_o (drec_ready),
    .wr_ready_i (mem_wready),
    .wr_valid_o (mem_wvalid),
    .wr_addr_o  (mem_waddr),
    .wr_data_o  (mem_wdata),
    .taken_o    (taken)
  );

  assign short_first = first_q && (taken < FIRST_LEN);
  assign br_target   = cw.addr[AW-1:0];
  assign misaligned  = |br_target[2:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      dev_q     <= '0;
      errdev_q  <= '0;
      op_q      <= '0;
      daddr_q   <= '0;
      pc_q      <= '0;
      cnt_q     <= '0;
      chain_q   <= 1'b0;
      first_q   <= 1'b0;
      prev_br_q <= 1'b0;
      psw_q     <= '0;
      done_q    <= 1'b0;
      wait_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_req) begin
            dev_q     <= dev_num;
            op_q      <= OP_LOAD_READ;
            daddr_q   <= '0;
            cnt_q     <= FIRST_LEN;
            chain_q   <= 1'b1;
            first_q   <= 1'b1;
            prev_br_q <= 1'b0;
            pc_q      <= '0;
            wait_q    <= 1'b0;
            st_q      <= ST_CMD;
          end
        end
        ST_CMD: begin
          if (dcmd_ready) st_q <= ST_XFER;
        end
        ST_XFER: begin
          if (dend_valid) begin
            if (dend_err || short_first) begin
              wait_q   <= 1'b1;
              errdev_q <= dev_q;
              st_q     <= ST_IDLE;
            end else if (chain_q) begin
              pc_q <= pc_q + STEP;
              st_q <= ST_FETCH;
            end else begin
              st_q <= ST_PSW;
            end
          end
        end
        ST_FETCH: st_q <= ST_DEC;
        ST_DEC: begin
          if (cw.is_branch) begin
            if (prev_br_q || misaligned) begin
              wait_q   <= 1'b1;
              errdev_q <= dev_q;
              st_q     <= ST_IDLE;
            end else begin
              pc_q      <= br_target;
              prev_br_q <= 1'b1;
              st_q      <= ST_FETCH;
            end
          end else if (cw.is_invalid) begin
            wait_q   <= 1'b1;
            errdev_q <= dev_q;
            st_q     <= ST_IDLE;
          end else begin
            op_q      <= cw.op;
            daddr_q   <= cw.addr[AW-1:0];
            cnt_q     <= CNT_W'(cw.count);
            chain_q   <= cw.chain;
            first_q   <= 1'b0;
            prev_br_q <= 1'b0;
            st_q      <= ST_CMD;
          end
        end
        ST_PSW: st_q <= ST_PDONE;
        ST_PDONE: begin
          psw_q  <= mem_rdata;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dcmd_valid = (st_q == ST_CMD);
  assign dcmd_op    = op_q;
  assign dcmd_dev   = dev_q;
  assign mem_ren    = (st_q == ST_FETCH) || (st_q == ST_PSW);
  assign mem_raddr  = (st_q == ST_PSW) ? '0 : pc_q;
  assign done_o     = done_q;
  assign psw_o      = psw_q;
  assign wait_o     = wait_q;
  assign err_dev_o  = errdev_q;

  // R1: accepted request yields the synthesised read to the sampled device
  a_r1_first_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && load_req) |=>
      (dcmd_valid && dcmd_op == OP_LOAD_READ && dcmd_dev == $past(dev_num)));

  // R10: an offered command is held until taken
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dcmd_valid && !dcmd_ready) |=>
      (dcmd_valid && $stable(dcmd_op) && $stable(dcmd_dev)));

  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R5: completion and abort never coincide
  a_r5_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !wait_o);

  // R6: the wait state persists until a new request
  a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_o && !load_req) |=> wait_o);

  // R6: no device command is offered while waiting
  a_r6_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> !dcmd_valid);
endmodule

// File: tb/boot_loader_tb_top.sv
module boot_loader_tb_top;
  localparam int AW = 12;
  localparam int DEV_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic load_req;
  logic [DEV_W-1:0] dev_num;
  logic dcmd_valid, dcmd_ready;
  logic [7:0] dcmd_op;
  logic [DEV_W-1:0] dcmd_dev;
  logic drec_valid, drec_ready;
  logic [7:0] drec_data;
  logic dend_valid, dend_err;
  logic mem_wvalid, mem_wready;
  logic [AW-1:0] mem_waddr;
  logic [7:0] mem_wdata;
  logic mem_ren;
  logic [AW-1:0] mem_raddr;
  logic [63:0] mem_rdata;
  logic done_o, wait_o;
  logic [63:0] psw_o;
  logic [DEV_W-1:0] err_dev_o;

  boot_loader #(.AW(AW), .DEV_W(DEV_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_req(load_req), .dev_num(dev_num),
    .dcmd_valid(dcmd_valid), .dcmd_ready(dcmd_ready), .dcmd_op(dcmd_op),
    .dcmd_dev(dcmd_dev), .drec_valid(drec_valid), .drec_ready(drec_ready),
    .drec_data(drec_data), .dend_valid(dend_valid), .dend_err(dend_err),
    .mem_wvalid(mem_wvalid), .mem_wready(mem_wready), .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata), .mem_ren(mem_ren), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .done_o(done_o), .psw_o(psw_o), .wait_o(wait_o),
    .err_dev_o(err_dev_o)
  );

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // memory model: byte writes, double-word reads with one cycle latency
  logic [7:0] mem [0:(1<<AW)-1];
  function automatic logic [63:0] rd64(logic [AW-1:0] a);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) r = {r[55:0], mem[a + AW'(i)]};
    return r;
  endfunction
  always @(posedge clk) begin
    if (mem_wvalid && mem_wready) mem[mem_waddr] <= mem_wdata;
    if (mem_ren) mem_rdata <= rd64(mem_raddr);
  end

  // random back-pressure
  bit bp_on = 1'b1;
  always @(negedge clk) begin
    dcmd_ready <= bp_on ? ($urandom % 2 == 0) : 1'b1;
    mem_wready <= bp_on ? ($urandom % 4 != 0) : 1'b1;
  end

  // device script
  logic [7:0] rec_data [0:7][0:63];
  int rec_len [0:7];
  bit rec_err [0:7];
  logic [7:0] got_op [0:7];
  logic [DEV_W-1:0] got_dev [0:7];
  int ncmd = 0;
  int cbase = 0;
  int end_cyc = 0;

  initial begin
    drec_valid = 1'b0; drec_data = '0; dend_valid = 1'b0; dend_err = 1'b0;
    forever begin
      @(negedge clk); #1;
      if (dcmd_valid && dcmd_ready) begin
        int k;
        k = ncmd - cbase;
        got_op[k] = dcmd_op;
        got_dev[k] = dcmd_dev;
        ncmd = ncmd + 1;
        @(posedge clk);
        for (int i = 0; i < rec_len[k]; i++) begin
          repeat ($urandom % 3) begin @(negedge clk); drec_valid = 1'b0; end
          @(negedge clk);
          drec_valid = 1'b1;
          drec_data = rec_data[k][i];
          #1;
          while (!drec_ready) begin @(negedge clk); #1; end
        end
        @(negedge clk);
        drec_valid = 1'b0;
        dend_valid = 1'b1;
        dend_err = rec_err[k];
        end_cyc = cyc;
        @(negedge clk);
        dend_valid = 1'b0;
        dend_err = 1'b0;
      end
    end
  end

  function automatic logic [63:0] ccw(logic [7:0] op, logic [23:0] a, bit ch, logic [15:0] n);
    return {op, a, 1'b0, ch, 6'b0, 8'h00, n};
  endfunction

  function automatic logic [7:0] pat(int k, int i, int s);
    return 8'((s * 37 + k * 16 + i * 5 + 1) & 255);
  endfunction

  task automatic put_dw(int k, int off, logic [63:0] dw);
    for (int i = 0; i < 8; i++) rec_data[k][off + i] = dw[63 - 8*i -: 8];
  endtask

  task automatic set_rec(int k, int len, bit err, int s);
    for (int i = 0; i < len; i++) rec_data[k][i] = pat(k, i, s);
    rec_len[k] = len;
    rec_err[k] = err;
  endtask

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_block(string req, int addr, int k, int n);
    bit ok = 1'b1;
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (mem[AW'(addr + i)] !== rec_data[k][i]) begin ok = 1'b0; bad = i; end
    check(ok, req, "stored block", mem[AW'(addr + bad)], rec_data[k][bad]);
  endtask

  task automatic start_load(logic [DEV_W-1:0] d);
    @(negedge clk);
    for (int i = 0; i < (1<<AW); i++) mem[i] = 8'hA5;
    cbase = ncmd;
    load_req = 1'b1;
    dev_num = d;
    @(negedge clk);
    load_req = 1'b0;
  endtask

  // outcome: 1 = done, 2 = wait, 0 = timeout
  task automatic wait_end(bit inject, output int oc, output int seen);
    bit injected = 1'b0;
    oc = 0; seen = 0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk); #2;
      load_req = 1'b0;
      if (done_o) begin oc = 1; seen = cyc; break; end
      if (wait_o) begin oc = 2; seen = cyc; break; end
      if (inject && !injected && ncmd - cbase >= 2) begin
        load_req = 1'b1; dev_num = 8'hEE; injected = 1'b1;
      end
    end
  endtask

  task automatic run_std(logic [DEV_W-1:0] d, logic [63:0] psw,
                         logic [7:0] opa, int bufa, int cnta, int lena,
                         logic [7:0] opb, int bufb, int cntb, int lenb,
                         bit inject, int s);
    int oc, seen, dcyc;
    set_rec(0, 24, 1'b0, s);
    put_dw(0, 0, psw);
    put_dw(0, 8, ccw(opa, 24'(bufa), 1'b1, 16'(cnta)));
    put_dw(0, 16, ccw(opb, 24'(bufb), 1'b0, 16'(cntb)));
    set_rec(1, lena, 1'b0, s);
    set_rec(2, lenb, 1'b0, s);
    start_load(d);
    wait_end(inject, oc, seen);
    dcyc = end_cyc;
    check(oc == 1, "R5", "load completes", 64'(oc), 64'd1);
    check(psw_o == psw, "R5", "state word", psw_o, psw);
    check(seen - dcyc == 3, "R5", "done delay", 64'(seen - dcyc), 64'd3);
    @(negedge clk);
    check(done_o == 1'b0, "R5", "done one cycle", 64'(done_o), 64'd0);
    check(ncmd - cbase == 3, "R9", "command count", 64'(ncmd - cbase), 64'd3);
    check(got_op[0] == 8'h02 && got_dev[0] == d, "R1", "implied command",
          {got_op[0], got_dev[0]}, {8'h02, d});
    check(got_op[1] == opa && got_op[2] == opb && got_dev[2] == d, "R3",
          "chained opcodes", {got_op[1], got_op[2]}, {opa, opb});
    chk_block("R1", 0, 0, 24);
    chk_block("R2", bufa, 1, cnta);
    chk_block("R2", bufb, 2, cntb);
    if (lena > cnta)
      check(mem[AW'(bufa + cnta)] == 8'hA5, "R2", "excess dropped",
            mem[AW'(bufa + cnta)], 8'hA5);
  endtask

  // generic abort scenario: expect wait with given command count
  task automatic expect_wait(string req, logic [DEV_W-1:0] d, int ncmds, bit timed);
    int oc, seen;
    start_load(d);
    wait_end(1'b0, oc, seen);
    check(oc == 2, req, "enters wait", 64'(oc), 64'd2);
    if (timed) check(seen - end_cyc == 1, req, "wait delay", 64'(seen - end_cyc), 64'd1);
    check(err_dev_o == d, req, "failing device", err_dev_o, d);
    repeat (12) @(negedge clk);
    check(ncmd - cbase == ncmds && wait_o, req, "halted", 64'(ncmd - cbase), 64'(ncmds));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int oc, seen;
    void'($urandom(32'd2024));
    rst_n = 1'b0; load_req = 1'b0; dev_num = '0;
    repeat (3) @(negedge clk);
    check(!done_o && !wait_o && !dcmd_valid && !mem_wvalid, "R6", "reset state",
          {done_o, wait_o, dcmd_valid, mem_wvalid}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: the command is offered in the cycle after the accepting edge
    bp_on = 1'b0;
    set_rec(0, 24, 1'b0, 3);
    put_dw(0, 8, ccw(8'h00, 24'h0, 1'b0, 16'd0));
    cbase = ncmd;
    load_req = 1'b1; dev_num = 8'h5A;
    @(negedge clk);
    load_req = 1'b0;
    check(dcmd_valid && dcmd_op == 8'h02 && dcmd_dev == 8'h5A, "R1", "first command timing",
          {dcmd_valid, dcmd_op, dcmd_dev}, {1'b1, 8'h02, 8'h5A});
    wait_end(1'b0, oc, seen);
    check(oc == 2, "R8", "invalid opcode aborts", 64'(oc), 64'd2);
    bp_on = 1'b1;

    // directed normal load with excess bytes on the first data command
    run_std(8'h05, 64'h0123_4567_89AB_CDEF, 8'h06, 'h200, 16, 20, 8'h06, 'h300, 8, 8, 1'b0, 1);

    // R4: the loaded data becomes more command words via a branch
    set_rec(0, 24, 1'b0, 2);
    put_dw(0, 0, 64'hFEDC_BA98_7654_3210);
    put_dw(0, 8, ccw(8'h06, 24'h100, 1'b1, 16'd16));
    put_dw(0, 16, ccw(8'h08, 24'h100, 1'b0, 16'd0));
    set_rec(1, 16, 1'b0, 2);
    put_dw(1, 0, ccw(8'h0E, 24'h400, 1'b1, 16'd4));
    put_dw(1, 8, ccw(8'h06, 24'h500, 1'b0, 16'd4));
    set_rec(2, 4, 1'b0, 2);
    set_rec(3, 4, 1'b0, 2);
    start_load(8'h03);
    wait_end(1'b0, oc, seen);
    check(oc == 1 && psw_o == 64'hFEDC_BA98_7654_3210, "R4", "branch load done",
          psw_o, 64'hFEDC_BA98_7654_3210);
    check(ncmd - cbase == 4, "R4", "branch issues no command", 64'(ncmd - cbase), 64'd4);
    check(got_op[2] == 8'h0E && got_op[3] == 8'h06, "R4", "branched opcodes",
          {got_op[2], got_op[3]}, 16'h0E06);
    chk_block("R4", 'h400, 2, 4);
    chk_block("R4", 'h500, 3, 4);

    // R6: error status on the second command
    set_rec(0, 24, 1'b0, 4);
    put_dw(0, 8, ccw(8'h06, 24'h200, 1'b1, 16'd4));
    put_dw(0, 16, ccw(8'h06, 24'h300, 1'b0, 16'd4));
    set_rec(1, 4, 1'b1, 4);
    expect_wait("R6", 8'h09, 2, 1'b1);

    // R9: restart from wait clears it in the next cycle
    @(negedge clk);
    load_req = 1'b1; dev_num = 8'h11;
    cbase = ncmd;
    set_rec(0, 24, 1'b0, 5);
    put_dw(0, 8, ccw(8'h00, 24'h0, 1'b0, 16'd0));
    @(negedge clk);
    load_req = 1'b0;
    check(wait_o == 1'b0, "R9", "wait cleared", 64'(wait_o), 64'd0);
    wait_end(1'b0, oc, seen);

    // R7: short first record
    set_rec(0, 20, 1'b0, 6);
    expect_wait("R7", 8'h21, 1, 1'b1);

    // R4: branch followed by branch
    set_rec(0, 24, 1'b0, 7);
    put_dw(0, 8, ccw(8'h08, 24'h10, 1'b0, 16'd0));
    put_dw(0, 16, ccw(8'h18, 24'h8, 1'b0, 16'd0));
    expect_wait("R4", 8'h22, 1, 1'b0);

    // R4: branch to a misaligned address
    set_rec(0, 24, 1'b0, 8);
    put_dw(0, 8, ccw(8'h08, 24'h0C, 1'b0, 16'd0));
    expect_wait("R4", 8'h23, 1, 1'b0);

    // R8: invalid opcode in the second word
    set_rec(0, 24, 1'b0, 9);
    put_dw(0, 8, ccw(8'h06, 24'h200, 1'b1, 16'd4));
    put_dw(0, 16, ccw(8'h30, 24'h300, 1'b0, 16'd4));
    set_rec(1, 4, 1'b0, 9);
    expect_wait("R8", 8'h24, 2, 1'b0);

    // random loads, one with a request injected mid-load (R9)
    for (int it = 0; it < 8; it++) begin
      logic [63:0] p;
      int ca, cb;
      p = {$urandom, $urandom};
      ca = 1 + $urandom % 12;
      cb = 1 + $urandom % 12;
      run_std(8'($urandom), p,
              {4'($urandom), 4'h6}, 'h200 + 8 * ($urandom % 16), ca, ca + $urandom % 3,
              {4'($urandom), 4'h2}, 'h400 + 8 * ($urandom % 16), cb, cb + $urandom % 3,
              it == 3, 10 + it);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule